// File: doc/BRIEF.md
# Triggered Vertical Ramp Generator with Amplitude Loop

The block produces a digital vertical-scan sawtooth that has no oscillator of its own. Every accepted rising edge on the sync input starts a flyback, where the ramp is held at zero for a fixed number of clocks, and a blanking interval whose length comes from a programmable input. After flyback the ramp climbs by a slope increment on each clock until the next accepted edge arrives. If that edge is late, the ramp holds at full scale. While blanking is active, sync edges are ignored.

A slow control loop keeps the amplitude independent of the field rate. At each accepted edge it samples the peak the ramp has reached. If the peak is above a reference window, it lowers the slope register by a fixed step. If the peak is below the window, it raises the slope by the same step. The slope saturates at programmable limits. The ramp is the upper 16 bits of a 24-bit saturating phase accumulator. The analog output stage that follows the ramp is outside this block.

Top module: `trig_ramp_gen`

## Requirements
- R1: After reset `ramp_o` is 0, and `blank_o` and `flyback_o` are both 0.
- R2: There is no free-running timebase. Until the first accepted trigger after reset, `ramp_o` stays 0 however long the block waits.
- R3: A trigger is accepted on a clock edge where `sync_i` is 1, `sync_i` was 0 at the previous edge, and blanking is inactive. From the next cycle on, `blank_o` and `flyback_o` are both 1.
- R4: `flyback_o` stays high for exactly FLY_CYC cycles after an accepted trigger, and `ramp_o` is 0 throughout that time.
- R5: `blank_o` stays high for exactly the value of `blank_len_i` captured at the accepted trigger, counted in cycles. A captured value of 0 counts as 1. Changes to `blank_len_i` after capture have no effect on the current interval.
- R6: After flyback the 24-bit accumulator grows by the slope on every clock. `ramp_o` is accumulator bits [23:8]. After k increments, `ramp_o` equals (k*slope)>>8.
- R7: Rising edges of `sync_i` while `blank_o` is high are ignored: the blanking length and the ramp are not affected. A `sync_i` level held high past the end of blanking does not trigger.
- R8: The accumulator saturates at 0xFFFFFF, so `ramp_o` holds 0xFFFF when the next trigger is late.
- R9: At every accepted trigger except the first after reset, the peak is the `ramp_o` value just before that trigger. If peak > REF_LVL+REF_TOL, the slope drops by SLOPE_STEP. If peak < REF_LVL-REF_TOL, the slope rises by SLOPE_STEP. Otherwise the slope is unchanged. The new slope drives the following field.
- R10: The slope starts at SLOPE_INIT after reset and is clamped to the range [SLOPE_MIN, SLOPE_MAX].
- R11: With a steady trigger period, for which a slope inside the limits can reach the reference, the peak settles inside REF_LVL±REF_TOL. This holds for different periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Vertical sync; rising edge requests a new field |
| blank_len_i | input | BLANK_W | Blanking length in clocks, captured at trigger |
| ramp_o | output | RAMP_W | Ramp value |
| blank_o | output | 1 | Blanking active |
| flyback_o | output | 1 | Flyback active, ramp held at zero |

## Verification
The bench drives single-clock sync pulses at several fixed periods and predicts every field's peak and an early-scan ramp value from the slope model. Comparing those predictions tells a wrong increment count, a wrong flyback length or a wrong loop direction apart.

A sweep of blanking lengths, including 0 and 1, together with extra pulses or a sync level held high inside the blanking, separates correct gating from retriggering.

Long periods force accumulator clamping and drive the slope to its lower limit. A very short period drives the slope to its upper limit. Two moderate periods show that the peak settles inside the reference window independently of rate.

// File: rtl/trig_ramp_pkg.sv
package trig_ramp_pkg;
  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_e;
endpackage

// File: rtl/trig_ramp_timing.sv
module trig_ramp_timing #(
  parameter int BLANK_W = 12,
  parameter int FLY_CYC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [BLANK_W-1:0] blank_len_i,
  output logic               trig_o,
  output logic               blank_o,
  output logic               fly_o,
  output logic               run_o
);
  localparam int FLY_W = $clog2(FLY_CYC + 1);
  localparam logic [FLY_W-1:0] FLY_LOAD = FLY_W'(FLY_CYC);

  logic               sync_q;
  logic               run_q;
  logic [BLANK_W-1:0] blank_cnt;
  logic [BLANK_W-1:0] blank_load;
  logic [FLY_W-1:0]   fly_cnt;

  assign blank_load = (blank_len_i == '0) ? BLANK_W'(1) : blank_len_i;
  // edge only counts when blanking has expired
  assign trig_o = sync_i && !sync_q && (blank_cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 1'b0;
      run_q     <= 1'b0;
      blank_cnt <= '0;
      fly_cnt   <= '0;
    end else begin
      sync_q <= sync_i;
      if (trig_o) run_q <= 1'b1;
      if (trig_o)                 blank_cnt <= blank_load;
      else if (blank_cnt != '0)   blank_cnt <= blank_cnt - 1'b1;
      if (trig_o)                 fly_cnt <= FLY_LOAD;
      else if (fly_cnt != '0)     fly_cnt <= fly_cnt - 1'b1;
    end
  end

  assign blank_o = (blank_cnt != '0);
  assign fly_o   = (fly_cnt != '0);
  assign run_o   = run_q;

  // R3
  trig_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> (blank_o && fly_o));
  // R7
  blank_no_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_cnt > BLANK_W'(1)) |=> (blank_o && blank_cnt < $past(blank_cnt)));
  // R4
  fly_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fly_o && !trig_o) |=> (fly_cnt == $past(fly_cnt) - 1'b1));
endmodule

// File: rtl/trig_ramp_acc.sv
module trig_ramp_acc #(
  parameter int ACC_W  = 24,
  parameter int RAMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              fly_i,
  input  logic              run_i,
  input  logic [ACC_W-1:0]  slope_i,
  output logic [RAMP_W-1:0] ramp_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, slope_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    acc_q <= '0;
    else if (trig_i)                acc_q <= '0;
    else if (run_i && !fly_i)       acc_q <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
  end

  assign ramp_o = acc_q[ACC_W-1 -: RAMP_W];

  // R4
  fly_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fly_i |-> (acc_q == '0));
  // R2
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (acc_q == '0));
  // R8
  ramp_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !fly_i && !trig_i) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/trig_ramp_slope.sv
module trig_ramp_slope
  import trig_ramp_pkg::*;
#(
  parameter int          ACC_W      = 24,
  parameter int          RAMP_W     = 16,
  parameter int unsigned REF_LVL    = 32'hB000,
  parameter int unsigned REF_TOL    = 32'h0600,
  parameter int unsigned SLOPE_STEP = 32'h000100,
  parameter int unsigned SLOPE_INIT = 32'h001000,
  parameter int unsigned SLOPE_MIN  = 32'h000010,
  parameter int unsigned SLOPE_MAX  = 32'h100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              run_i,
  input  logic [RAMP_W-1:0] peak_i,
  output logic [ACC_W-1:0]  slope_o
);
  localparam logic [RAMP_W:0] HI_V = (RAMP_W+1)'(REF_LVL + REF_TOL);
  localparam logic [RAMP_W:0] LO_V = (RAMP_W+1)'((REF_LVL > REF_TOL) ? REF_LVL - REF_TOL : 0);
  localparam logic [ACC_W:0]  STEP_V = (ACC_W+1)'(SLOPE_STEP);
  localparam logic [ACC_W:0]  MIN_V  = (ACC_W+1)'(SLOPE_MIN);
  localparam logic [ACC_W:0]  MAX_V  = (ACC_W+1)'(SLOPE_MAX);
  localparam logic [ACC_W-1:0] INIT_V = ACC_W'(SLOPE_INIT);
  localparam logic [ACC_W-1:0] LMIN   = ACC_W'(SLOPE_MIN);
  localparam logic [ACC_W-1:0] LMAX   = ACC_W'(SLOPE_MAX);
  localparam logic [ACC_W-1:0] LSTEP  = ACC_W'(SLOPE_STEP);

  adj_e             adj;
  logic [ACC_W-1:0] slope_q, slope_nxt;
  logic [ACC_W:0]   up_v;
  logic             upd;

  assign upd  = trig_i && run_i;  // first field after reset has no valid peak
  assign up_v = {1'b0, slope_q} + STEP_V;

  always_comb begin
    if ({1'b0, peak_i} > HI_V)      adj = ADJ_DOWN;
    else if ({1'b0, peak_i} < LO_V) adj = ADJ_UP;
    else                            adj = ADJ_HOLD;
  end

  always_comb begin
    unique case (adj)
      ADJ_UP:   slope_nxt = (up_v > MAX_V) ? LMAX : up_v[ACC_W-1:0];
      ADJ_DOWN: slope_nxt = ({1'b0, slope_q} < MIN_V + STEP_V) ? LMIN : slope_q - LSTEP;
      default:  slope_nxt = slope_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  slope_q <= INIT_V;
    else if (upd) slope_q <= slope_nxt;
  end

  assign slope_o = slope_q;

  // R10
  slope_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slope_q >= LMIN) && (slope_q <= LMAX));
  // R9
  slope_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(slope_q));
  // R9
  slope_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && ({1'b0, peak_i} > HI_V)) |=> (slope_q <= $past(slope_q)));
endmodule

// File: rtl/trig_ramp_gen.sv
module trig_ramp_gen #(
  parameter int          RAMP_W     = 16,
  parameter int          ACC_W      = 24,
  parameter int          BLANK_W    = 12,
  parameter int          FLY_CYC    = 8,
  parameter int unsigned REF_LVL    = 32'hB000,
  parameter int unsigned REF_TOL    = 32'h0600,
  parameter int unsigned SLOPE_STEP = 32'h000100,
  parameter int unsigned SLOPE_INIT = 32'h001000,
  parameter int unsigned SLOPE_MIN  = 32'h000010,
  parameter int unsigned SLOPE_MAX  = 32'h100000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [BLANK_W-1:0] blank_len_i,
  output logic [RAMP_W-1:0]  ramp_o,
  output logic               blank_o,
  output logic               flyback_o
);
  logic             trig, fly, run;
  logic [ACC_W-1:0] slope;
  logic [RAMP_W-1:0] ramp;

  trig_ramp_timing #(.BLANK_W(BLANK_W), .FLY_CYC(FLY_CYC)) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .blank_len_i(blank_len_i),
    .trig_o(trig), .blank_o(blank_o), .fly_o(fly), .run_o(run)
  );

  trig_ramp_acc #(.ACC_W(ACC_W), .RAMP_W(RAMP_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .fly_i(fly), .run_i(run),
    .slope_i(slope), .ramp_o(ramp)
  );

  trig_ramp_slope #(
    .ACC_W(ACC_W), .RAMP_W(RAMP_W), .REF_LVL(REF_LVL), .REF_TOL(REF_TOL),
    .SLOPE_STEP(SLOPE_STEP), .SLOPE_INIT(SLOPE_INIT),
    .SLOPE_MIN(SLOPE_MIN), .SLOPE_MAX(SLOPE_MAX)
  ) u_slope (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .run_i(run),
    .peak_i(ramp), .slope_o(slope)
  );

  assign ramp_o    = ramp;
  assign flyback_o = fly;
endmodule

// File: tb/trig_ramp_gen_bench.sv
`timescale 1ns/1ps
module trig_ramp_gen_bench;
  localparam int    FLY  = 3;
  localparam int    BW   = 8;
  localparam longint REF  = 'hC000;
  localparam longint TOL  = 'h0800;
  localparam longint STEP = 'h0800;
  localparam longint INIT = 'h10000;
  localparam longint SMIN = 'h4000;
  localparam longint SMAX = 'h40000;
  localparam longint HI   = REF + TOL;
  localparam longint LO   = REF - TOL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync = 1'b0;
  logic [BW-1:0] blank_len = '0;
  logic [15:0]   ramp;
  logic          blank, fly;

  int     n_chk = 0;
  int     n_err = 0;
  bit     done = 1'b0;
  longint m_slope = INIT;
  bit     m_run = 1'b0;
  int     last_p = 0;

  always #2 clk = ~clk;

  trig_ramp_gen #(
    .RAMP_W(16), .ACC_W(24), .BLANK_W(BW), .FLY_CYC(FLY),
    .REF_LVL(32'hC000), .REF_TOL(32'h0800), .SLOPE_STEP(32'h0800),
    .SLOPE_INIT(32'h10000), .SLOPE_MIN(32'h4000), .SLOPE_MAX(32'h40000)
  ) u_trig_ramp_gen (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .blank_len_i(blank_len),
    .ramp_o(ramp), .blank_o(blank), .flyback_o(fly)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_ramp(input longint k, input longint s);
    longint v;
    if (k <= 0) return 0;
    v = k * s;
    if (v > 'hFFFFFF) v = 'hFFFFFF;
    return v >> 8;
  endfunction

  // called at a negedge; mode 1 = extra pulse in blanking, mode 2 = level held across blanking end
  task automatic field(input int p, input int l, input int mode);
    longint ep;
    int bcnt = 0;
    int fcnt = 0;
    int lef  = (l == 0) ? 1 : l;
    ep = m_run ? exp_ramp(last_p - 1 - FLY, m_slope) : 0;
    if (ep == 'hFFFF) chk(ramp == 16'(ep), "R8 clamped peak", ramp, ep);
    else              chk(ramp == 16'(ep), "R9 field peak", ramp, ep);
    if (m_run) begin
      if (ep > HI)      m_slope = (m_slope - STEP < SMIN) ? SMIN : m_slope - STEP;
      else if (ep < LO) m_slope = (m_slope + STEP > SMAX) ? SMAX : m_slope + STEP;
    end
    m_run  = 1'b1;
    last_p = p;
    blank_len = BW'(l);
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
    for (int i = 1; i < p; i++) begin
      if (blank) bcnt++;
      if (fly)   fcnt++;
      if (i == 1) begin
        chk(blank && fly, "R3 blank and flyback start", {blank, fly}, 3);
        chk(ramp == 16'd0, "R4 ramp zero in flyback", ramp, 0);
      end
      if (i == FLY + 5)
        chk(ramp == 16'(exp_ramp(i - 1 - FLY, m_slope)), "R6 scan value", ramp,
            exp_ramp(i - 1 - FLY, m_slope));
      if (i == 2) blank_len = '1;
      if (mode == 1) begin
        if (i == 2) sync = 1'b1;
        if (i == 3) sync = 1'b0;
      end else if (mode == 2) begin
        if (i == 2) sync = 1'b1;
        if (i == l + 3) sync = 1'b0;
      end
      @(negedge clk);
    end
    if (mode != 0) chk(bcnt == lef, "R7 blank length with ignored sync", bcnt, lef);
    else           chk(bcnt == lef, "R5 blank length", bcnt, lef);
    chk(fcnt == FLY, "R4 flyback length", fcnt, FLY);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ramp == 16'd0 && !blank && !fly, "R1 reset state", {ramp, blank, fly}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ramp == 16'd0 && !blank && !fly, "R1 after release", {ramp, blank, fly}, 0);
    repeat (60) @(negedge clk);
    chk(ramp == 16'd0, "R2 no ramp without trigger", ramp, 0);
    chk(!blank && !fly, "R2 no blanking without trigger", {blank, fly}, 0);

    // blanking length sweep
    field(60, 0, 0);
    field(60, 1, 0);
    field(60, 2, 0);
    field(60, 5, 0);
    field(60, FLY, 0);
    field(60, 30, 0);
    // ignored sync in blanking
    field(80, 10, 1);
    field(80, 10, 2);
    field(80, 10, 0);

    // rate independence at two periods
    for (int f = 0; f < 40; f++) field(400, 8, 0);
    chk(longint'(ramp) >= LO && longint'(ramp) <= HI, "R11 settled at period 400", ramp, REF);
    for (int f = 0; f < 40; f++) field(200, 8, 0);
    chk(longint'(ramp) >= LO && longint'(ramp) <= HI, "R11 settled at period 200", ramp, REF);

    // lower slope limit (ramp clamps every field)
    for (int f = 0; f < 30; f++) field(2000, 8, 0);
    chk(m_slope == SMIN, "R10 model reached lower limit", m_slope, SMIN);
    // upper slope limit
    for (int f = 0; f < 130; f++) field(24, 8, 0);
    chk(m_slope == SMAX, "R10 model reached upper limit", m_slope, SMAX);
    field(24, 8, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule